// File: doc/BRIEF.md
# Pixel Plot Unit with Coordinate Wrap

This block is the single-pixel drawing path of a display drawing engine. It keeps its own x and y coordinates. When a command starts it turns them into a logical byte address and a bit field inside that byte. The address and field depend on the display mode, the colour depth and the image width. It then fetches the destination byte, merges the foreground colour into it, and writes the byte back. For 16-bit pixels it does this for two bytes.

The merge runs in three steps. A transparency test on the source pixel comes first. A four-entry truth-table logical operation against the destination bits follows. Last, a per-bank write mask is applied. After the write, each coordinate can be incremented, decremented or held, and it wraps by masking. A command-executing flag is visible for the whole operation. A completion flag is set at the end of each command and drives the interrupt line when enabled.

Top module: `pxplot_unit`

## Requirements
- R1: When a command starts with both X-step control bits low, the internal x is loaded with the destination X masked to the image width: 0xFF, 0x1FF, 0x3FF or 0x7FF for width codes 0..3 (256..2048 pixels). X = 300 at width 256 therefore plots x = 0x2C.
- R2: A command start never reloads y. A start with either X-step bit high keeps the internal x from the previous command.
- R3: A pulse on the Y-write strobe loads y from the Y input in the next cycle, whether or not a command is running. If it falls in the same cycle as a post-plot step, the written value wins.
- R4: After each plot, x and y are each held, incremented (step enable=1, down=0) or decremented (enable=1, down=1). The new value is masked by the image width and by the image height. The height is 512 KiB divided by the line stride.
- R5: The byte address is y times the line stride plus the byte offset of x. The stride is 128 bytes in mode 0 and 256 bytes in mode 1, both at 4 bpp whatever the depth and width inputs say. In modes 2 and 3 the stride is width×bpp/8, with depth codes 0..3 meaning 2, 4, 8 and 16 bpp.
- R6: At 2 and 4 bpp the lowest 2 or 4 colour bits are placed with pixel 0 in the most significant field of the byte. At 8 bpp colour bits 7:0 form the byte. At 16 bpp the low colour byte goes to address 2x and the high byte to 2x+1.
- R7: Each byte is read before it is written. The written bit is lop_code[{src,dst}], so 4'b1100 is copy, 4'b0110 is XOR and 4'b1000 is AND. Bits outside the pixel field keep the read value.
- R8: When transparency is enabled and the source pixel is zero (the full 16 bits at 16 bpp), no memory access is made. The command still completes and steps. The test ignores the logical operation.
- R9: A bit whose selected write mask bit is 0 keeps the read value. In modes 2 and 3, even addresses use mask 0 and odd addresses use mask 1. In modes 0 and 1, the top address bit picks the mask.
- R10: `busy` is high from the cycle after an accepted start until the command ends. A start while busy is ignored, and memory is requested only while busy.
- R11: The completion flag is set at the end of every command and holds until `int_ack`. A set wins over a clear in the same cycle. `irq` is high only when the flag and `int_en` are both high.
- R12: After reset, `busy`, `int_flag`, `irq` and `mem_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Command start pulse |
| dx_in | input | X_W | Destination X register |
| dy_wr | input | 1 | Y register write strobe |
| dy_in | input | Y_W | Destination Y register value |
| fg_color | input | 16 | Foreground colour |
| adv_x_en | input | 1 | Step x after plot |
| adv_x_dec | input | 1 | x steps down |
| adv_y_en | input | 1 | Step y after plot |
| adv_y_dec | input | 1 | y steps down |
| mode | input | 2 | 0/1 fixed-width tiled modes, 2 bitmap, 3 bitmap-alike |
| depth | input | 2 | Colour depth code |
| width_sel | input | 2 | Image width code |
| lop_code | input | 4 | Logical operation truth table |
| transp_en | input | 1 | Transparency enable |
| wmask0 | input | 8 | Write mask, bank 0 |
| wmask1 | input | 8 | Write mask, bank 1 |
| int_en | input | 1 | Completion interrupt enable |
| int_ack | input | 1 | Clear completion flag |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Logical byte address |
| mem_wdata | output | 8 | Write data |
| mem_ack | input | 1 | Request accepted; read data valid |
| mem_rdata | input | 8 | Read data |
| busy | output | 1 | Command executing |
| int_flag | output | 1 | Completion flag |
| irq | output | 1 | Interrupt request |

## Verification
Two functions can land on the same clock edge. A Y-register write can coincide with the post-plot y step. A completion-flag clear can coincide with the flag being set by the command's own end. The bench waits for the final write acknowledge, then drives the strobe in the one following cycle, which is the finishing cycle. It judges the result from outside the block. For the Y write, the address of the next plot must use the written y and not the stepped one. For the flag, it must still read 1.

// File: rtl/pxplot_pkg.sv
package pxplot_pkg;

    localparam int ADDR_W_DEF = 19;
    localparam int X_W_DEF    = 11;
    localparam int MIN_SLOG   = 6;

    localparam logic [1:0] MD_TILE256 = 2'd0;
    localparam logic [1:0] MD_TILE512 = 2'd1;

    localparam logic [1:0] BPP2  = 2'd0;
    localparam logic [1:0] BPP4  = 2'd1;
    localparam logic [1:0] BPP8  = 2'd2;
    localparam logic [1:0] BPP16 = 2'd3;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RD   = 2'd1,
        ST_WR   = 2'd2,
        ST_FIN  = 2'd3
    } state_e;

    typedef struct packed {
        logic x_en;
        logic x_dec;
        logic y_en;
        logic y_dec;
    } adv_t;

    function automatic logic [1:0] eff_depth(input logic [1:0] md, input logic [1:0] bpp);
        return (md[1] == 1'b0) ? BPP4 : bpp;
    endfunction

    function automatic int width_log(input logic [1:0] md, input logic [1:0] wsel);
        if (md == MD_TILE256) return 8;
        if (md == MD_TILE512) return 9;
        return 8 + int'(wsel);
    endfunction

    function automatic logic [7:0] lop_apply(input logic [3:0] lop, input logic [7:0] sc,
                                             input logic [7:0] dc);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = lop[{sc[i], dc[i]}];
        return r;
    endfunction

endpackage

// File: rtl/pxplot_coord.sv
module pxplot_coord #(
    parameter int X_W = 11,
    parameter int Y_W = 13
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_x,
    input  logic [X_W-1:0]   dx,
    input  logic             dy_wr,
    input  logic [Y_W-1:0]   dy,
    input  logic             step,
    input  pxplot_pkg::adv_t adv,
    input  logic [X_W-1:0]   xmask,
    input  logic [Y_W-1:0]   ymask,
    output logic [X_W-1:0]   x_q,
    output logic [Y_W-1:0]   y_q
);
    logic [X_W-1:0] x_step;
    logic [Y_W-1:0] y_step;

    always_comb begin
        x_step = (adv.x_dec ? x_q - X_W'(1) : x_q + X_W'(1)) & xmask;
        y_step = (adv.y_dec ? y_q - Y_W'(1) : y_q + Y_W'(1)) & ymask;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            x_q <= '0;
            y_q <= '0;
        end else begin
            if (load_x)
                x_q <= dx & xmask;
            else if (step && adv.x_en)
                x_q <= x_step;
            // a register write takes priority over the post-plot step
            if (dy_wr)
                y_q <= dy & ymask;
            else if (step && adv.y_en)
                y_q <= y_step;
        end
    end
endmodule

// File: rtl/pxplot_addr.sv
module pxplot_addr #(
    parameter int ADDR_W = 19,
    parameter int X_W    = 11,
    parameter int Y_W    = 13
) (
    input  logic [X_W-1:0]    x,
    input  logic [Y_W-1:0]    y,
    input  logic [1:0]        mode,
    input  logic [1:0]        bpp,
    input  logic [1:0]        wsel,
    input  logic              idx,
    output logic [ADDR_W-1:0] addr,
    output logic [7:0]        fmask,
    output logic [2:0]        shift,
    output logic [1:0]        depth,
    output logic              bank,
    output logic [X_W-1:0]    xmask,
    output logic [Y_W-1:0]    ymask
);
    import pxplot_pkg::*;

    int                wl;
    int                sl;
    logic [X_W-1:0]    xm;
    logic [Y_W-1:0]    ym;
    logic [ADDR_W-1:0] off;

    always_comb begin
        depth = eff_depth(mode, bpp);
        wl    = width_log(mode, wsel);
        sl    = wl + int'(depth) - 2;
        xmask = X_W'((1 << wl) - 1);
        ymask = Y_W'((1 << (ADDR_W - sl)) - 1);
        xm    = x & xmask;
        ym    = y & ymask;
        shift = 3'd0;
        fmask = 8'hFF;
        case (depth)
            BPP2: begin
                off   = ADDR_W'(xm >> 2);
                shift = 3'(2 * (3 - int'(xm[1:0])));
                fmask = 8'h03 << shift;
            end
            BPP4: begin
                off   = ADDR_W'(xm >> 1);
                shift = xm[0] ? 3'd0 : 3'd4;
                fmask = 8'h0F << shift;
            end
            BPP8:    off = ADDR_W'(xm);
            default: off = ADDR_W'({xm, idx});
        endcase
        addr = (ADDR_W'(ym) << sl) + off;
        bank = mode[1] ? addr[0] : addr[ADDR_W-1];
    end
endmodule

// File: rtl/pxplot_merge.sv
module pxplot_merge (
    input  logic [15:0] fg,
    input  logic [1:0]  depth,
    input  logic [2:0]  shift,
    input  logic [7:0]  fmask,
    input  logic        idx,
    input  logic [7:0]  dc,
    input  logic [3:0]  lop,
    input  logic        transp_en,
    input  logic [7:0]  wm0,
    input  logic [7:0]  wm1,
    input  logic        bank,
    output logic [7:0]  wdata,
    output logic        skip
);
    import pxplot_pkg::*;

    logic [7:0] pix;
    logic [7:0] sc;
    logic [7:0] wc;
    logic [7:0] en;

    always_comb begin
        case (depth)
            BPP2:    pix = {6'd0, fg[1:0]};
            BPP4:    pix = {4'd0, fg[3:0]};
            BPP8:    pix = fg[7:0];
            default: pix = idx ? fg[15:8] : fg[7:0];
        endcase
        skip  = transp_en && ((depth == BPP16) ? (fg == 16'd0) : (pix == 8'd0));
        sc    = pix << shift;
        wc    = lop_apply(lop, sc, dc);
        en    = fmask & (bank ? wm1 : wm0);
        wdata = (wc & en) | (dc & ~en);
    end
endmodule

// File: rtl/pxplot_unit.sv
module pxplot_unit #(
    parameter int ADDR_W = pxplot_pkg::ADDR_W_DEF,
    parameter int X_W    = pxplot_pkg::X_W_DEF,
    localparam int Y_W   = ADDR_W - pxplot_pkg::MIN_SLOG
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [X_W-1:0]    dx_in,
    input  logic              dy_wr,
    input  logic [Y_W-1:0]    dy_in,
    input  logic [15:0]       fg_color,
    input  logic              adv_x_en,
    input  logic              adv_x_dec,
    input  logic              adv_y_en,
    input  logic              adv_y_dec,
    input  logic [1:0]        mode,
    input  logic [1:0]        depth,
    input  logic [1:0]        width_sel,
    input  logic [3:0]        lop_code,
    input  logic              transp_en,
    input  logic [7:0]        wmask0,
    input  logic [7:0]        wmask1,
    input  logic              int_en,
    input  logic              int_ack,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic              mem_ack,
    input  logic [7:0]        mem_rdata,
    output logic              busy,
    output logic              int_flag,
    output logic              irq
);
    import pxplot_pkg::*;

    state_e         state;
    logic           idx;
    logic [7:0]     dbuf;
    adv_t           adv;
    logic           load_x;
    logic           step;
    logic [X_W-1:0] x_q;
    logic [Y_W-1:0] y_q;
    logic [X_W-1:0] xmask;
    logic [Y_W-1:0] ymask;
    logic [7:0]     fmask;
    logic [2:0]     shift;
    logic [1:0]     depth_eff;
    logic           bank;
    logic           skip;

    assign adv    = '{x_en: adv_x_en, x_dec: adv_x_dec, y_en: adv_y_en, y_dec: adv_y_dec};
    assign load_x = (state == ST_IDLE) && start && !adv_x_en && !adv_x_dec;
    assign step   = (state == ST_FIN);

    pxplot_coord #(.X_W(X_W), .Y_W(Y_W)) u_coord (
        .clk(clk), .rst(rst), .load_x(load_x), .dx(dx_in), .dy_wr(dy_wr), .dy(dy_in),
        .step(step), .adv(adv), .xmask(xmask), .ymask(ymask), .x_q(x_q), .y_q(y_q)
    );

    pxplot_addr #(.ADDR_W(ADDR_W), .X_W(X_W), .Y_W(Y_W)) u_addr (
        .x(x_q), .y(y_q), .mode(mode), .bpp(depth), .wsel(width_sel), .idx(idx),
        .addr(mem_addr), .fmask(fmask), .shift(shift), .depth(depth_eff), .bank(bank),
        .xmask(xmask), .ymask(ymask)
    );

    pxplot_merge u_merge (
        .fg(fg_color), .depth(depth_eff), .shift(shift), .fmask(fmask), .idx(idx),
        .dc(dbuf), .lop(lop_code), .transp_en(transp_en), .wm0(wmask0), .wm1(wmask1),
        .bank(bank), .wdata(mem_wdata), .skip(skip)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            idx      <= 1'b0;
            dbuf     <= '0;
            int_flag <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    state <= ST_RD;
                    idx   <= 1'b0;
                end
                ST_RD: begin
                    if (skip)
                        state <= ST_FIN;
                    else if (mem_ack) begin
                        dbuf  <= mem_rdata;
                        state <= ST_WR;
                    end
                end
                ST_WR: if (mem_ack) begin
                    if (depth_eff == BPP16 && !idx) begin
                        idx   <= 1'b1;
                        state <= ST_RD;
                    end else
                        state <= ST_FIN;
                end
                default: state <= ST_IDLE;
            endcase
            if (state == ST_FIN)
                int_flag <= 1'b1;
            else if (int_ack)
                int_flag <= 1'b0;
        end
    end

    assign mem_req = ((state == ST_RD) && !skip) || (state == ST_WR);
    assign mem_we  = (state == ST_WR);
    assign busy    = (state != ST_IDLE);
    assign irq     = int_flag && int_en;
endmodule

// File: rtl/pxplot_chk.sv
module pxplot_chk #(
    parameter int ADDR_W = 19,
    parameter int X_W    = 11,
    parameter int Y_W    = 13
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              busy,
    input logic              dy_wr,
    input logic [Y_W-1:0]    dy_in,
    input logic [X_W-1:0]    dx_in,
    input logic              adv_x_en,
    input logic              adv_x_dec,
    input logic [X_W-1:0]    x_q,
    input logic [Y_W-1:0]    y_q,
    input logic [X_W-1:0]    xmask,
    input logic [Y_W-1:0]    ymask,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_ack,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              int_flag
);
    p_xload_r1: assert property (@(posedge clk) disable iff (rst)
        (!busy && start && !adv_x_en && !adv_x_dec) |=> (x_q == $past(dx_in & xmask)));

    p_ywrite_r3: assert property (@(posedge clk) disable iff (rst)
        dy_wr |=> (y_q == $past(dy_in & ymask)));

    p_hold_req_r7: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    p_read_first_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we) |-> $past(mem_req && !mem_we && mem_ack));

    p_start_busy_r10: assert property (@(posedge clk) disable iff (rst)
        (!busy && start) |=> busy);

    p_req_in_cmd_r10: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> busy);

    p_done_flag_r11: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> int_flag);
endmodule

bind pxplot_unit pxplot_chk #(.ADDR_W(ADDR_W), .X_W(X_W), .Y_W(Y_W)) u_chk (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .dy_wr(dy_wr), .dy_in(dy_in),
    .dx_in(dx_in), .adv_x_en(adv_x_en), .adv_x_dec(adv_x_dec), .x_q(x_q), .y_q(y_q),
    .xmask(xmask), .ymask(ymask), .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack),
    .mem_addr(mem_addr), .int_flag(int_flag)
);

// File: tb/pxplot_unit_tb.sv
module pxplot_unit_tb;
    localparam int ADDR_W = 19;
    localparam int X_W    = 11;
    localparam int Y_W    = 13;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic [X_W-1:0]    dx_in = '0;
    logic              dy_wr = 1'b0;
    logic [Y_W-1:0]    dy_in = '0;
    logic [15:0]       fg_color = '0;
    logic              adv_x_en = 1'b0, adv_x_dec = 1'b0, adv_y_en = 1'b0, adv_y_dec = 1'b0;
    logic [1:0]        mode = 2'd2, depth = 2'd2, width_sel = 2'd0;
    logic [3:0]        lop_code = 4'b1100;
    logic              transp_en = 1'b0;
    logic [7:0]        wmask0 = 8'hFF, wmask1 = 8'hFF;
    logic              int_en = 1'b0, int_ack = 1'b0;
    logic              mem_req, mem_we, mem_ack = 1'b0;
    logic [ADDR_W-1:0] mem_addr;
    logic [7:0]        mem_wdata, mem_rdata = '0;
    logic              busy, int_flag, irq;

    int checks = 0;
    int errors = 0;
    int wcnt = 0;
    int rcnt = 0;
    int unsigned wlog_a [0:7];
    logic [7:0]  wlog_d [0:7];
    logic [7:0]  mem [int unsigned];

    always #5 clk = ~clk;

    pxplot_unit u_dut (
        .clk(clk), .rst(rst), .start(start), .dx_in(dx_in), .dy_wr(dy_wr), .dy_in(dy_in),
        .fg_color(fg_color), .adv_x_en(adv_x_en), .adv_x_dec(adv_x_dec),
        .adv_y_en(adv_y_en), .adv_y_dec(adv_y_dec), .mode(mode), .depth(depth),
        .width_sel(width_sel), .lop_code(lop_code), .transp_en(transp_en),
        .wmask0(wmask0), .wmask1(wmask1), .int_en(int_en), .int_ack(int_ack),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .busy(busy), .int_flag(int_flag), .irq(irq)
    );

    function automatic logic [7:0] mrd(input int unsigned a);
        if (mem.exists(a)) return mem[a];
        return a[7:0] ^ a[15:8] ^ 8'h3C;
    endfunction

    // memory model: one wait cycle, then acknowledge
    always @(posedge clk) begin
        mem_ack   <= mem_req && !mem_ack;
        mem_rdata <= mrd(int'(mem_addr));
        if (mem_req && mem_ack) begin
            if (mem_we) begin
                mem[int'(mem_addr)] = mem_wdata;
                wlog_a[wcnt % 8] <= int'(mem_addr);
                wlog_d[wcnt % 8] <= mem_wdata;
                wcnt <= wcnt + 1;
            end else
                rcnt <= rcnt + 1;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic set_y(input int v);
        dy_in = Y_W'(v);
        dy_wr = 1'b1;
        @(posedge clk); #1;
        dy_wr = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (!busy) break;
        end
    endtask

    task automatic run_cmd();
        start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        wait_idle();
    endtask

    // start a command and pulse dy_wr/int_ack in its finishing cycle
    task automatic run_with_fin_pulse(input logic do_y, input int yv, input logic do_ack);
        start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (mem_req && mem_we && mem_ack) break;
        end
        @(posedge clk); #1;
        dy_in = Y_W'(yv);
        dy_wr = do_y;
        int_ack = do_ack;
        @(posedge clk); #1;
        dy_wr = 1'b0;
        int_ack = 1'b0;
        wait_idle();
    endtask

    task automatic set_adv(input logic xe, input logic xd, input logic ye, input logic yd);
        adv_x_en = xe; adv_x_dec = xd; adv_y_en = ye; adv_y_dec = yd;
    endtask

    task automatic plot8(input string req, input int exp_a, input int exp_d);
        int w0;
        w0 = wcnt;
        run_cmd();
        chk({req, " write count"}, wcnt - w0, 1);
        chk({req, " address"}, int'(wlog_a[w0 % 8]), exp_a);
        chk({req, " data"}, int'(wlog_d[w0 % 8]), exp_d);
    endtask

    task automatic t_reset();
        chk("R12 busy", int'(busy), 0);
        chk("R12 int_flag", int'(int_flag), 0);
        chk("R12 irq", int'(irq), 0);
        chk("R12 mem_req", int'(mem_req), 0);
    endtask

    task automatic t_mask_wrap();
        mode = 2'd2; depth = 2'd2; width_sel = 2'd0; set_adv(0, 0, 0, 0);
        set_y(5); dx_in = 11'd300; fg_color = 16'h005A;
        plot8("R1 x=300 masked to 0x2C", 5 * 256 + 16'h2C, 8'h5A);
        mode = 2'd3; set_y(1); dx_in = 11'd2; fg_color = 16'h0077;
        plot8("R5 mode3 as bitmap", 258, 8'h77);
    endtask

    task automatic t_tile_modes();
        int dc;
        mode = 2'd0; depth = 2'd2; width_sel = 2'd3;
        set_y(3); dx_in = 11'h105; fg_color = 16'h0007;
        dc = int'(mrd(386));
        plot8("R5 mode0 stride 128 low nibble", 386, (dc & 8'hF0) | 8'h07);
        mode = 2'd1; set_y(2); dx_in = 11'h1FE; fg_color = 16'h0009;
        dc = int'(mrd(767));
        plot8("R6 mode1 stride 256 high nibble", 767, (dc & 8'h0F) | 8'h90);
    endtask

    task automatic t_2bpp_lop();
        int dc;
        mode = 2'd2; depth = 2'd0; width_sel = 2'd1;
        set_y(1); dx_in = 11'd6; fg_color = 16'h0003; lop_code = 4'b0110;
        dc = int'(mrd(129));
        plot8("R7 xor 2bpp field[3:2]", 129, dc ^ 8'h0C);
        dx_in = 11'd4; fg_color = 16'h0001; lop_code = 4'b1000;
        dc = int'(mrd(129));
        plot8("R6 and 2bpp pixel0 top field", 129, (dc & 8'h3F) | (dc & 8'h40));
        lop_code = 4'b1100;
    endtask

    task automatic t_16bpp();
        int w0, r0;
        mode = 2'd2; depth = 2'd3; width_sel = 2'd2;
        set_y(1); dx_in = 11'd3; fg_color = 16'h1234;
        w0 = wcnt; r0 = rcnt;
        run_cmd();
        chk("R6 16bpp write count", wcnt - w0, 2);
        chk("R7 16bpp read count", rcnt - r0, 2);
        chk("R6 16bpp low addr", int'(wlog_a[w0 % 8]), 2054);
        chk("R6 16bpp low data", int'(wlog_d[w0 % 8]), 8'h34);
        chk("R6 16bpp high addr", int'(wlog_a[(w0 + 1) % 8]), 2055);
        chk("R6 16bpp high data", int'(wlog_d[(w0 + 1) % 8]), 8'h12);
    endtask

    task automatic t_wmask();
        int dc;
        mode = 2'd2; depth = 2'd2; width_sel = 2'd0;
        wmask0 = 8'h0F; wmask1 = 8'hF0; fg_color = 16'h00FF;
        set_y(0); dx_in = 11'd10;
        dc = int'(mrd(10));
        plot8("R9 even uses mask0", 10, (dc & 8'hF0) | 8'h0F);
        dx_in = 11'd11;
        dc = int'(mrd(11));
        plot8("R9 odd uses mask1", 11, (dc & 8'h0F) | 8'hF0);
        mode = 2'd0; set_y(2048); dx_in = 11'd0; fg_color = 16'h000F;
        dc = int'(mrd(32'h40000));
        plot8("R9 mode0 upper bank uses mask1", 32'h40000, (dc & 8'h0F) | 8'hF0);
        wmask0 = 8'hFF; wmask1 = 8'hFF;
    endtask

    task automatic t_transp();
        int w0, r0;
        mode = 2'd2; depth = 2'd2; width_sel = 2'd0; transp_en = 1'b1;
        set_y(0); dx_in = 11'd20; fg_color = 16'h0000;
        w0 = wcnt; r0 = rcnt;
        run_cmd();
        chk("R8 zero pixel no write", wcnt - w0, 0);
        chk("R8 zero pixel no read", rcnt - r0, 0);
        chk("R8 still completes", int'(int_flag), 1);
        mode = 2'd0; fg_color = 16'h0030;
        run_cmd();
        chk("R8 4bpp zero nibble skipped", wcnt - w0, 0);
        mode = 2'd2; lop_code = 4'b0110; fg_color = 16'h0011;
        plot8("R8 nonzero pixel written", 20, int'(mrd(20)) ^ 8'h11);
        lop_code = 4'b1100; transp_en = 1'b0; fg_color = 16'h0000;
        plot8("R8 disabled zero written", 20, 0);
    endtask

    task automatic t_advance();
        mode = 2'd2; depth = 2'd2; width_sel = 2'd0; fg_color = 16'h0042;
        set_adv(0, 0, 0, 0); set_y(0); dx_in = 11'd255;
        plot8("R1 load x 255", 255, 8'h42);
        set_adv(1, 0, 0, 0); dx_in = 11'd77; dy_in = 13'd99;
        plot8("R2 no reload when x steps", 255, 8'h42);
        set_adv(0, 1, 1, 1);
        plot8("R4 x 255+1 wraps to 0", 0, 8'h42);
        set_adv(0, 1, 0, 0);
        plot8("R4 y 0-1 wraps to 2047", 2047 * 256, 8'h42);
        set_adv(1, 1, 0, 0);
        plot8("R2 x held", 2047 * 256, 8'h42);
        set_adv(0, 1, 1, 0);
        plot8("R4 x 0-1 wraps to 255", 2047 * 256 + 255, 8'h42);
        set_adv(0, 1, 0, 0);
        plot8("R4 y 2047+1 wraps to 0", 255, 8'h42);
    endtask

    task automatic t_collision();
        int w0;
        set_adv(0, 1, 1, 0);
        w0 = wcnt;
        run_with_fin_pulse(1'b1, 10, 1'b0);
        chk("R3 collision plot addr", int'(wlog_a[w0 % 8]), 255);
        set_adv(0, 1, 0, 0);
        plot8("R3 y write wins over step", 10 * 256 + 255, 8'h42);
    endtask

    task automatic t_busy();
        int w0;
        set_adv(0, 0, 0, 0); dx_in = 11'd30; w0 = wcnt;
        start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        @(negedge clk);
        chk("R10 busy after start", int'(busy), 1);
        #1; dx_in = 11'd40; start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        wait_idle();
        repeat (4) @(negedge clk);
        chk("R10 second start ignored count", wcnt - w0, 1);
        chk("R10 first command address", int'(wlog_a[w0 % 8]), 10 * 256 + 30);
        chk("R10 idle after", int'(busy), 0);
    endtask

    task automatic t_irq();
        int_ack = 1'b1;
        @(posedge clk); #1;
        int_ack = 1'b0;
        @(negedge clk);
        chk("R11 ack clears", int'(int_flag), 0);
        int_en = 1'b0;
        run_cmd();
        chk("R11 flag set", int'(int_flag), 1);
        chk("R11 irq masked", int'(irq), 0);
        int_en = 1'b1;
        @(negedge clk);
        chk("R11 irq enabled", int'(irq), 1);
        int_ack = 1'b1;
        @(posedge clk); #1;
        int_ack = 1'b0;
        @(negedge clk);
        chk("R11 irq cleared", int'(irq), 0);
        run_with_fin_pulse(1'b0, 0, 1'b1);
        chk("R11 set beats ack", int'(int_flag), 1);
        int_en = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_mask_wrap();
        t_tile_modes();
        t_2bpp_lop();
        t_16bpp();
        t_wmask();
        t_transp();
        t_advance();
        t_collision();
        t_busy();
        t_irq();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule